// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block is a purely combinational correction stage that sits after a byte-wide adder, subtracter or multiplier, or ahead of a divider. The datapath does the binary arithmetic first. This unit then rewrites the 16-bit accumulator pair so that the result is a valid decimal value. The pair is a high byte and a low byte.

A 3-bit opcode selects one of six correction rules. Two rules work on packed BCD, with two digits per byte. Four rules work on unpacked digits, with one digit per byte:

- adjust after add
- adjust after subtract
- adjust after multiply, which splits a binary byte into tens and units
- adjust before divide, which folds two digits into one binary byte

Along with the corrected pair, the unit returns the carry and auxiliary-carry flags, and sign, zero and parity flags for the new low byte.

Top module: `decadj_unit`

## Requirements
- R1: With `op_sel` = 0 (packed adjust after add), 0x06 is added to the low byte when its low nibble is above 9 or `ac_in` is 1, and `ac_out` equals that condition. 0x60 is added when the original low byte is above 0x99 or `cy_in` is 1, and `cy_out` equals that second condition. The high byte is unchanged.
- R2: With `op_sel` = 1 (packed adjust after subtract), the same two conditions subtract 0x06 and 0x60 instead, and the flags are set as in R1. The high byte is unchanged.
- R3: With `op_sel` = 2 (unpacked adjust after add), when the low nibble of the low byte is above 9 or `ac_in` is 1, the unit adds 6 to the low byte and adds 1 to the high byte.
- R4: With `op_sel` = 3 (unpacked adjust after subtract), under the same condition as R3, the unit subtracts 6 from the low byte and subtracts 1 from the high byte.
- R5: For opcodes 2 and 3, bits 7:4 of `res_lo` are always 0, and `cy_out` and `ac_out` both equal the adjust condition.
- R6: With `op_sel` = 4 (adjust after multiply), `res_hi` is the low byte divided by ten and `res_lo` is the remainder.
- R7: For opcode 4 and a low byte from 0x00 to 0x63, both result bytes are at most 9, and `res_hi`*10 + `res_lo` equals the input low byte.
- R8: With `op_sel` = 5 (adjust before divide), `res_lo` is (high byte × 10 + low byte) modulo 256, and `res_hi` is 0.
- R9: For every opcode, `sign_out` is bit 7 of `res_lo`, `zero_out` is 1 exactly when `res_lo` is 0, and `par_out` is 1 when `res_lo` has an even number of one bits.
- R10: For opcodes 4 and 5, `cy_out` and `ac_out` pass `cy_in` and `ac_in` through unchanged.
- R11: For opcodes 6 and 7, both bytes and both carry flags pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Adjust rule select (0..5 defined, 6..7 pass-through) |
| acc_hi | input | 8 | High accumulator byte |
| acc_lo | input | 8 | Low accumulator byte |
| cy_in | input | 1 | Incoming carry/borrow flag |
| ac_in | input | 1 | Incoming auxiliary (nibble) carry flag |
| res_hi | output | 8 | Adjusted high byte |
| res_lo | output | 8 | Adjusted low byte |
| cy_out | output | 1 | Resulting carry flag |
| ac_out | output | 1 | Resulting auxiliary carry flag |
| sign_out | output | 1 | Bit 7 of the adjusted low byte |
| zero_out | output | 1 | Adjusted low byte is zero |
| par_out | output | 1 | Adjusted low byte has even parity |

## Verification
The unit holds no state, so a wrong adjust condition shows at the ports in the same cycle as the stimulus that triggers it. It appears as a low byte that is 6 or 0x60 off, or as a high byte that is off by one. The risky cases sit on the thresholds:

- a low nibble of exactly 9 or 10;
- a low byte of exactly 0x99 or 0x9A;
- a raised auxiliary carry on an otherwise small nibble.

The bench therefore aims its vectors at these points. It also sweeps the whole 0..99 range for the multiply split.

// File: rtl/decadj_unit.sv
module decadj_unit (
  input  logic [2:0] op_sel,
  input  logic [7:0] acc_hi,
  input  logic [7:0] acc_lo,
  input  logic       cy_in,
  input  logic       ac_in,
  output logic [7:0] res_hi,
  output logic [7:0] res_lo,
  output logic       cy_out,
  output logic       ac_out,
  output logic       sign_out,
  output logic       zero_out,
  output logic       par_out
);

  localparam logic [2:0] OP_PADD = 3'd0;
  localparam logic [2:0] OP_PSUB = 3'd1;
  localparam logic [2:0] OP_UADD = 3'd2;
  localparam logic [2:0] OP_USUB = 3'd3;
  localparam logic [2:0] OP_MUL  = 3'd4;
  localparam logic [2:0] OP_DIV  = 3'd5;

  logic nib_fix, byte_fix;
  logic [7:0] fix_lo, fix_hi;
  logic [3:0] unp_lo;

  assign nib_fix  = (acc_lo[3:0] > 4'd9) | ac_in;
  assign byte_fix = (acc_lo > 8'h99) | cy_in;
  assign fix_lo   = nib_fix  ? 8'h06 : 8'h00;
  assign fix_hi   = byte_fix ? 8'h60 : 8'h00;

  always_comb begin
    res_hi = acc_hi;
    res_lo = acc_lo;
    cy_out = cy_in;
    ac_out = ac_in;
    unp_lo = acc_lo[3:0];
    case (op_sel)
      OP_PADD: begin
        res_lo = acc_lo + fix_lo + fix_hi;
        ac_out = nib_fix;
        cy_out = byte_fix;
      end
      OP_PSUB: begin
        res_lo = acc_lo - fix_lo - fix_hi;
        ac_out = nib_fix;
        cy_out = byte_fix;
      end
      OP_UADD: begin
        unp_lo = acc_lo[3:0] + fix_lo[3:0];
        res_lo = {4'h0, unp_lo};
        res_hi = acc_hi + {7'd0, nib_fix};
        ac_out = nib_fix;
        cy_out = nib_fix;
      end
      OP_USUB: begin
        unp_lo = acc_lo[3:0] - fix_lo[3:0];
        res_lo = {4'h0, unp_lo};
        res_hi = acc_hi - {7'd0, nib_fix};
        ac_out = nib_fix;
        cy_out = nib_fix;
      end
      OP_MUL: begin
        res_hi = acc_lo / 8'd10;
        res_lo = acc_lo % 8'd10;
      end
      OP_DIV: begin
        res_lo = acc_hi * 8'd10 + acc_lo;
        res_hi = 8'h00;
      end
      default: ;
    endcase
  end

  assign sign_out = res_lo[7];
  assign zero_out = (res_lo == 8'h00);
  assign par_out  = ~^res_lo;

  always_comb begin
    if (op_sel == OP_UADD || op_sel == OP_USUB) begin
      AST_UNPACKED_TOP_CLEAR: assert (res_lo[7:4] == 4'h0); // R5
      AST_UNPACKED_FLAGS_PAIR: assert (cy_out == ac_out); // R5
    end
    if (op_sel == OP_MUL && acc_lo <= 8'h63) begin
      AST_MUL_DIGITS_VALID: assert (res_hi <= 8'd9 && res_lo <= 8'd9 && (res_hi * 8'd10 + res_lo) == acc_lo); // R7
    end
    if (op_sel == OP_DIV) begin
      AST_DIV_HIGH_CLEAR: assert (res_hi == 8'h00); // R8
    end
    if (op_sel == OP_MUL || op_sel == OP_DIV || op_sel[2:1] == 2'b11) begin
      AST_FLAGS_KEPT: assert (cy_out == cy_in && ac_out == ac_in); // R10
    end
    if (op_sel[2:1] == 2'b11) begin
      AST_PASS_BYTES: assert (res_hi == acc_hi && res_lo == acc_lo); // R11
    end
  end

endmodule

// File: tb/decadj_unit_tb.sv
module decadj_unit_tb;

  typedef struct {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       cy;
    logic       ac;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_sel = 3'd6;
  logic [7:0] acc_hi = 8'h00, acc_lo = 8'h00;
  logic       cy_in = 1'b0, ac_in = 1'b0;
  logic [7:0] res_hi, res_lo;
  logic       cy_out, ac_out, sign_out, zero_out, par_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  decadj_unit u_dut (
    .op_sel(op_sel), .acc_hi(acc_hi), .acc_lo(acc_lo), .cy_in(cy_in), .ac_in(ac_in),
    .res_hi(res_hi), .res_lo(res_lo), .cy_out(cy_out), .ac_out(ac_out),
    .sign_out(sign_out), .zero_out(zero_out), .par_out(par_out)
  );

  task automatic drive(input logic [2:0] op, input logic [7:0] h, input logic [7:0] l,
                       input logic c, input logic a,
                       input logic [7:0] eh, input logic [7:0] el,
                       input logic ec, input logic ea, input string r);
    exp_t e;
    @(posedge clk);
    op_sel = op; acc_hi = h; acc_lo = l; cy_in = c; ac_in = a;
    e.hi = eh; e.lo = el; e.cy = ec; e.ac = ea; e.req = r;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    logic es, ez, ep;
    forever begin
      @(negedge clk);
      if (rst_n && sb_q.size() > 0) begin
        e = sb_q.pop_front();
        es = e.lo[7];
        ez = (e.lo == 8'h00);
        ep = ~^e.lo;
        checks++;
        if (res_hi !== e.hi || res_lo !== e.lo || cy_out !== e.cy || ac_out !== e.ac) begin
          errors++;
          $display("FAIL %s: got hi=%h lo=%h cy=%b ac=%b, expected hi=%h lo=%h cy=%b ac=%b",
                   e.req, res_hi, res_lo, cy_out, ac_out, e.hi, e.lo, e.cy, e.ac);
        end
        checks++;
        if (sign_out !== es || zero_out !== ez || par_out !== ep) begin
          errors++;
          $display("FAIL R9 (%s): got s=%b z=%b p=%b, expected s=%b z=%b p=%b",
                   e.req, sign_out, zero_out, par_out, es, ez, ep);
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle/reset state: pass-through opcode, R11
    drive(3'd6, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R11");
    // R1 packed add
    drive(3'd0, 8'h11, 8'h3C, 1'b0, 1'b0, 8'h11, 8'h42, 1'b0, 1'b1, "R1");
    drive(3'd0, 8'h00, 8'h9A, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, "R1");
    drive(3'd0, 8'h00, 8'h81, 1'b0, 1'b1, 8'h00, 8'h87, 1'b0, 1'b1, "R1");
    drive(3'd0, 8'h00, 8'h45, 1'b0, 1'b0, 8'h00, 8'h45, 1'b0, 1'b0, "R1");
    drive(3'd0, 8'h00, 8'h99, 1'b0, 1'b0, 8'h00, 8'h99, 1'b0, 1'b0, "R1");
    drive(3'd0, 8'h00, 8'h12, 1'b1, 1'b0, 8'h00, 8'h72, 1'b1, 1'b0, "R1");
    // R2 packed sub
    drive(3'd1, 8'h22, 8'h1E, 1'b0, 1'b1, 8'h22, 8'h18, 1'b0, 1'b1, "R2");
    drive(3'd1, 8'h00, 8'hDE, 1'b1, 1'b1, 8'h00, 8'h78, 1'b1, 1'b1, "R2");
    drive(3'd1, 8'h00, 8'h29, 1'b0, 1'b0, 8'h00, 8'h29, 1'b0, 1'b0, "R2");
    // R3 / R5 unpacked add
    drive(3'd2, 8'h00, 8'h0F, 1'b0, 1'b0, 8'h01, 8'h05, 1'b1, 1'b1, "R3");
    drive(3'd2, 8'h03, 8'h37, 1'b0, 1'b0, 8'h03, 8'h07, 1'b0, 1'b0, "R5");
    drive(3'd2, 8'h02, 8'h12, 1'b0, 1'b1, 8'h03, 8'h08, 1'b1, 1'b1, "R3");
    drive(3'd2, 8'h00, 8'h39, 1'b1, 1'b0, 8'h00, 8'h09, 1'b0, 1'b0, "R5");
    // R4 / R5 unpacked sub
    drive(3'd3, 8'h05, 8'hFE, 1'b0, 1'b1, 8'h04, 8'h08, 1'b1, 1'b1, "R4");
    drive(3'd3, 8'h01, 8'h04, 1'b0, 1'b0, 8'h01, 8'h04, 1'b0, 1'b0, "R4");
    drive(3'd3, 8'h00, 8'h3A, 1'b0, 1'b0, 8'hFF, 8'h04, 1'b1, 1'b1, "R5");
    // R6 / R10 multiply split with flags kept
    drive(3'd4, 8'h77, 8'h2D, 1'b1, 1'b0, 8'h04, 8'h05, 1'b1, 1'b0, "R6");
    drive(3'd4, 8'h00, 8'hFF, 1'b0, 1'b1, 8'd25, 8'd5, 1'b0, 1'b1, "R10");
    // R7 full 0..99 sweep
    for (int v = 0; v < 100; v++)
      drive(3'd4, 8'hAA, 8'(v), 1'b0, 1'b0, 8'(v / 10), 8'(v % 10), 1'b0, 1'b0, "R7");
    // R8 divide fold
    drive(3'd5, 8'h07, 8'h03, 1'b0, 1'b0, 8'h00, 8'h49, 1'b0, 1'b0, "R8");
    drive(3'd5, 8'h09, 8'h09, 1'b1, 1'b1, 8'h00, 8'h63, 1'b1, 1'b1, "R8");
    drive(3'd5, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, "R10");
    drive(3'd5, 8'h1A, 8'h06, 1'b0, 1'b0, 8'h00, 8'h0A, 1'b0, 1'b0, "R8");
    // R11 undefined opcodes
    drive(3'd6, 8'hAB, 8'hCD, 1'b1, 1'b0, 8'hAB, 8'hCD, 1'b1, 1'b0, "R11");
    drive(3'd7, 8'h12, 8'h80, 1'b0, 1'b1, 8'h12, 8'h80, 1'b0, 1'b1, "R11");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule